// File: doc/BRIEF.md
# GPIO Expander Register and Interrupt Core

This block is the register and change-interrupt core of an 8-bit general-purpose I/O expander that sits behind a serial target bus. A bit-level bus engine in front of it presents three things: each received target address with a valid pulse, register accesses as an index with write-data and a write strobe, or a read strobe, and a stop indication. The core matches the address against a fixed upper nibble combined with three strap pins. It opens an access window on a match and services register accesses only inside that window.

Four 8-bit registers are held: a read-only view of the synchronized pins, output data, a per-bit read polarity mask, and a direction mask. Pins whose direction bit is 0 are driven from the output data. Pins whose direction bit is 1 are inputs, and they take part in change detection against a snapshot that is taken whenever the input view is read. An active-low interrupt flags any input pin whose synchronized level differs from that snapshot.

A small control state machine sequences the block. ST_WARM lasts while the pin synchronizer fills after reset. ST_LOAD takes the first snapshot. ST_IDLE waits for an address. ST_ACTIVE services accesses. The transitions are as follows. ST_WARM goes to ST_LOAD when its counter reaches the synchronizer depth minus one. ST_LOAD goes to ST_IDLE after one cycle. ST_IDLE goes to ST_ACTIVE on a matching address. ST_ACTIVE goes to ST_IDLE on a non-matching address, or on a stop that has no address in the same cycle.

Top module: `gpx_core`

## Requirements
- R1: After reset, the output data register reads 0xFF, the polarity register reads 0x00 and the direction register reads 0xFF. As a result pin_oe is 0x00, pin_out is 0xFF and int_n is high.
- R2: The target address is {base, strap[2:0]}. The base is 4'b0100 when ALT_BASE=0 and 4'b0111 when ALT_BASE=1. A matching addr_vld pulses addr_ack in the following cycle and enters ST_ACTIVE. Any other address gives no addr_ack and leaves ST_ACTIVE.
- R3: wr_stb and rd_stb have no effect outside ST_ACTIVE, which covers warm-up, idle and after a mismatched address. A bus_stop in ST_ACTIVE returns the block to ST_IDLE.
- R4: Register indices are 0 = input view, 1 = output data, 2 = polarity and 3 = direction. A write to index 1, 2 or 3 takes effect at the strobe edge. A write to index 0 changes no register.
- R5: Per bit, pin_oe[i] is the inverse of direction bit i, and pin_out equals the output data register. Both follow a write in the cycle after the strobe.
- R6: rd_data is updated at the edge of rd_stb and holds its value otherwise. A read of index 0 returns the synchronized pins XOR the polarity mask. Indices 1 to 3 return the raw register. A pin change reaches the synchronized view two clock edges after it is applied.
- R7: int_n is low exactly when some pin with direction bit 1 has a synchronized level that differs from the snapshot. It falls two edges after such a pin change. Pins with direction bit 0 never assert it.
- R8: A read of index 0 loads the snapshot with the synchronized pins, so int_n is high in the next cycle unless a pin moved at that edge. Returning the pins to the snapshot value also releases int_n.
- R9: After reset, int_n is held high through ST_WARM and ST_LOAD, and the first snapshot is taken from the settled synchronizer. Pins that are static through reset therefore never assert int_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 3 | Address strap pins, low address bits |
| addr_vld | input | 1 | Received target address valid pulse |
| addr | input | 7 | Received 7-bit target address |
| bus_stop | input | 1 | End of bus transaction |
| reg_idx | input | 2 | Register index |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_stb | input | 1 | Register read strobe |
| rd_data | output | 8 | Register read data, valid after the strobe edge |
| addr_ack | output | 1 | Address matched, one cycle after addr_vld |
| pin_in | input | 8 | Pin levels as seen at the pads |
| pin_out | output | 8 | Pin drive data |
| pin_oe | output | 8 | Per-pin drive enable |
| int_n | output | 1 | Active-low change interrupt |

## Verification
The timing contract is as follows. Register writes, read data and addr_ack appear one edge after their strobe, pin_oe and pin_out follow a write one edge later, and a pin change reaches int_n and the input view after two edges. The bench drives every stimulus on a falling edge and samples on the falling edge that matches that count. Some checks sample one edge early on purpose, to show that the interrupt has not yet moved. Before any read of the input view, the bench leaves an extra idle cycle so that the synchronizer has settled. The sweeps cover all 128 addresses on two strap settings and both base variants, all 256 direction and polarity values, and every pin bit for change, restore, read-clear and output exclusion.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic [1:0] {
        ST_WARM   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_IDLE   = 2'd2,
        ST_ACTIVE = 2'd3
    } gpx_state_e;

    localparam int IDX_W = 2;

    localparam logic [IDX_W-1:0] IDX_INPUT  = 2'd0;
    localparam logic [IDX_W-1:0] IDX_OUTPUT = 2'd1;
    localparam logic [IDX_W-1:0] IDX_POLAR  = 2'd2;
    localparam logic [IDX_W-1:0] IDX_DIR    = 2'd3;

    localparam logic [3:0] BASE_STD = 4'b0100;
    localparam logic [3:0] BASE_ALT = 4'b0111;

    function automatic logic [6:0] tgt_addr_f(input logic alt, input logic [2:0] strap);
        return {(alt ? BASE_ALT : BASE_STD), strap};
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpx_addr_match.sv
module gpx_addr_match
    import gpx_pkg::*;
#(
    parameter bit ALT_BASE = 1'b0
) (
    input  logic [2:0] strap,
    input  logic       addr_vld,
    input  logic [6:0] addr,
    output logic       hit,
    output logic       miss
);

    logic [6:0] own_addr;

    always_comb begin
        own_addr = tgt_addr_f(ALT_BASE, strap);
        hit      = addr_vld && (addr == own_addr);
        miss     = addr_vld && (addr != own_addr);
    end

endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wr_data,
    input  logic [W-1:0]     pin_view,
    output logic [W-1:0]     out_q,
    output logic [W-1:0]     pol_q,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '1;
            pol_q <= '0;
            dir_q <= '1;
        end else if (wr_en) begin
            unique case (idx)
                IDX_INPUT:  ;
                IDX_OUTPUT: out_q <= wr_data;
                IDX_POLAR:  pol_q <= wr_data;
                IDX_DIR:    dir_q <= wr_data;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            IDX_INPUT:  rd_mux = pin_view ^ pol_q;
            IDX_OUTPUT: rd_mux = out_q;
            IDX_POLAR:  rd_mux = pol_q;
            IDX_DIR:    rd_mux = dir_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

endmodule

// File: rtl/gpx_chg_det.sv
module gpx_chg_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         capture,
    input  logic         armed,
    input  logic [W-1:0] pin_view,
    input  logic [W-1:0] dir_q,
    output logic         int_n
);

    logic [W-1:0] snap_q;
    logic [W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               snap_q <= '0;
        else if (load || capture) snap_q <= pin_view;
    end

    always_comb begin
        diff  = (pin_view ^ snap_q) & dir_q;
        int_n = !(armed && (|diff));
    end

endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit ALT_BASE    = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       strap,
    input  logic             addr_vld,
    input  logic [6:0]       addr,
    input  logic             bus_stop,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             wr_stb,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_stb,
    output logic [W-1:0]     rd_data,
    output logic             addr_ack,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe,
    output logic             int_n
);

    localparam int CNT_W = $clog2(SYNC_STAGES + 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(SYNC_STAGES - 1);

    gpx_state_e     state_q, state_d;
    logic [CNT_W-1:0] warm_cnt;
    logic           hit, miss;
    logic [W-1:0]   pin_sync;
    logic [W-1:0]   out_q, pol_q, dir_q;
    logic           acc_en, wr_en, rd_en, snap_load, snap_cap, armed;
    logic           ack_q;

    gpx_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpx_addr_match #(.ALT_BASE(ALT_BASE)) u_match (
        .strap    (strap),
        .addr_vld (addr_vld),
        .addr     (addr),
        .hit      (hit),
        .miss     (miss)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_WARM;
            warm_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WARM) warm_cnt <= warm_cnt + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARM:   if (warm_cnt == WARM_LAST) state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_IDLE;
            ST_IDLE:   if (hit) state_d = ST_ACTIVE;
            ST_ACTIVE: begin
                if (miss)                      state_d = ST_IDLE;
                else if (bus_stop && !addr_vld) state_d = ST_IDLE;
            end
        endcase
    end

    // state-derived controls
    always_comb begin
        acc_en    = 1'b0;
        snap_load = 1'b0;
        armed     = 1'b0;
        unique case (state_q)
            ST_WARM:   ;
            ST_LOAD:   snap_load = 1'b1;
            ST_IDLE:   armed = 1'b1;
            ST_ACTIVE: begin
                armed  = 1'b1;
                acc_en = 1'b1;
            end
        endcase
        wr_en    = acc_en && wr_stb;
        rd_en    = acc_en && rd_stb;
        snap_cap = rd_en && (reg_idx == IDX_INPUT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= hit && ((state_q == ST_IDLE) || (state_q == ST_ACTIVE));
    end

    gpx_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .idx      (reg_idx),
        .wr_data  (wr_data),
        .pin_view (pin_sync),
        .out_q    (out_q),
        .pol_q    (pol_q),
        .dir_q    (dir_q),
        .rd_data  (rd_data)
    );

    gpx_chg_det #(.W(W)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (snap_load),
        .capture  (snap_cap),
        .armed    (armed),
        .pin_view (pin_sync),
        .dir_q    (dir_q),
        .int_n    (int_n)
    );

    assign addr_ack = ack_q;
    assign pin_out  = out_q;
    assign pin_oe   = ~dir_q;

endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk
    import gpx_pkg::*;
#(
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input gpx_state_e       state_q,
    input logic             addr_vld,
    input logic             addr_ack,
    input logic             wr_stb,
    input logic             rd_stb,
    input logic [IDX_W-1:0] reg_idx,
    input logic [W-1:0]     wr_data,
    input logic [W-1:0]     pin_sync,
    input logic [W-1:0]     pin_out,
    input logic [W-1:0]     pin_oe,
    input logic             int_n
);

    // R2
    ack_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> $past(addr_vld));

    // R3
    idle_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACTIVE && wr_stb) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R4
    input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && wr_stb && reg_idx == IDX_INPUT)
        |=> ($stable(pin_out) && $stable(pin_oe)));

    // R5
    dir_drives_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && wr_stb && reg_idx == IDX_DIR)
        |=> (pin_oe == ~$past(wr_data)));

    // R8
    read_clears_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && rd_stb && reg_idx == IDX_INPUT)
        |=> (int_n || !$stable(pin_sync)));

    // R9
    warm_int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WARM || state_q == ST_LOAD) |-> int_n);

endmodule

bind gpx_core gpx_core_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .addr_vld (addr_vld),
    .addr_ack (addr_ack),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .reg_idx  (reg_idx),
    .wr_data  (wr_data),
    .pin_sync (pin_sync),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .int_n    (int_n)
);

// File: tb/gpx_core_bench.sv
module gpx_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       addr_vld = 1'b0;
    logic [6:0] addr = '0;
    logic       bus_stop = 1'b0;
    logic [1:0] reg_idx = '0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] pin_in = 8'hA5;
    logic [7:0] rd_data, pin_out, pin_oe, rd_data_alt, pin_out_alt, pin_oe_alt;
    logic       addr_ack, addr_ack_alt, int_n, int_n_alt;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gpx_core u_gpx_core (
        .clk(clk), .rst_n(rst_n), .strap(strap), .addr_vld(addr_vld), .addr(addr),
        .bus_stop(bus_stop), .reg_idx(reg_idx), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data), .addr_ack(addr_ack), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .int_n(int_n)
    );

    gpx_core #(.ALT_BASE(1'b1)) u_gpx_core_alt (
        .clk(clk), .rst_n(rst_n), .strap(strap), .addr_vld(addr_vld), .addr(addr),
        .bus_stop(bus_stop), .reg_idx(reg_idx), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data_alt), .addr_ack(addr_ack_alt), .pin_in(pin_in),
        .pin_out(pin_out_alt), .pin_oe(pin_oe_alt), .int_n(int_n_alt)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel(input logic [6:0] a);
        addr = a; addr_vld = 1'b1;
        cyc(1);
        addr_vld = 1'b0;
    endtask

    task automatic stop();
        bus_stop = 1'b1;
        cyc(1);
        bus_stop = 1'b0;
    endtask

    task automatic wr(input logic [1:0] i, input logic [7:0] d);
        reg_idx = i; wr_data = d; wr_stb = 1'b1;
        cyc(1);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [1:0] i);
        reg_idx = i; rd_stb = 1'b1;
        cyc(1);
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [6:0] me;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R9 int high during warm-up", {7'd0, int_n}, 8'h01);
        cyc(6);
        // R1 reset state, R9 static pins A5 keep int high after first snapshot
        check("R1 pin_oe reset", pin_oe, 8'h00);
        check("R1 pin_out reset", pin_out, 8'hFF);
        check("R9 int after warm-up", {7'd0, int_n}, 8'h01);
        // R3 strobes outside ST_ACTIVE
        wr(2'd3, 8'h00);
        cyc(1);
        check("R3 idle write ignored", pin_oe, 8'h00);
        rd(2'd3);
        check("R3 idle read ignored", rd_data, 8'h00);

        // R2 address sweep over two straps, both bases
        for (int s = 0; s < 2; s++) begin
            strap = (s == 0) ? 3'b101 : 3'b010;
            for (int a = 0; a < 128; a++) begin
                sel(7'(a));
                check("R2 ack std", {7'd0, addr_ack}, {7'd0, (7'(a) == {4'b0100, strap})});
                check("R2 ack alt", {7'd0, addr_ack_alt}, {7'd0, (7'(a) == {4'b0111, strap})});
                stop();
            end
        end
        me = {4'b0100, strap};

        // R1 readback of reset values, R4 writes
        sel(me);
        rd(2'd1); check("R1 output reg reset", rd_data, 8'hFF);
        rd(2'd2); check("R1 polarity reg reset", rd_data, 8'h00);
        rd(2'd3); check("R1 direction reg reset", rd_data, 8'hFF);
        wr(2'd1, 8'h3C); rd(2'd1); check("R4 output write", rd_data, 8'h3C);
        wr(2'd2, 8'h81); rd(2'd2); check("R4 polarity write", rd_data, 8'h81);
        wr(2'd3, 8'hF0); rd(2'd3); check("R4 direction write", rd_data, 8'hF0);
        wr(2'd0, 8'h55);
        rd(2'd1); check("R4 idx0 write keeps output", rd_data, 8'h3C);
        rd(2'd2); check("R4 idx0 write keeps polarity", rd_data, 8'h81);
        rd(2'd3); check("R4 idx0 write keeps direction", rd_data, 8'hF0);
        check("R5 pin_out follows output reg", pin_out, 8'h3C);

        // R5 direction sweep
        for (int d = 0; d < 256; d++) begin
            wr(2'd3, 8'(d));
            check("R5 pin_oe inverse of direction", pin_oe, ~8'(d));
        end
        wr(2'd1, 8'hC3);
        check("R5 pin_out", pin_out, 8'hC3);

        // R3 mismatched address closes window, bus_stop too
        sel(me ^ 7'h01);
        wr(2'd1, 8'h11); cyc(1);
        check("R3 write after mismatch ignored", pin_out, 8'hC3);
        sel(me);
        stop();
        wr(2'd1, 8'h22); cyc(1);
        check("R3 write after stop ignored", pin_out, 8'hC3);

        // R6 polarity sweep on input view
        sel(me);
        wr(2'd3, 8'hFF);
        for (int p = 0; p < 256; p++) begin
            pin_in = 8'(p * 7) ^ 8'h96;
            wr(2'd2, 8'(p));
            cyc(1);
            rd(2'd0);
            check("R6 input read xor polarity", rd_data, (8'(p * 7) ^ 8'h96) ^ 8'(p));
        end
        // R6 two-edge latency
        wr(2'd2, 8'h00);
        pin_in = 8'h0F;
        cyc(1);
        rd(2'd0);
        check("R6 pin change not yet visible after one edge", rd_data, 8'h69 ^ 8'h00 ^ 8'h69 ^ ((8'd255 * 7) ^ 8'h96));
        cyc(1);
        rd(2'd0);
        check("R6 pin change visible after two edges", rd_data, 8'h0F);
        cyc(2);
        check("R8 int high after capture", {7'd0, int_n}, 8'h01);

        // R7 / R8 per-bit change detection
        for (int i = 0; i < 8; i++) begin
            pin_in = 8'h0F ^ (8'h01 << i);
            cyc(1);
            check("R7 int still high after one edge", {7'd0, int_n}, 8'h01);
            cyc(1);
            check("R7 int low after two edges", {7'd0, int_n}, 8'h00);
            pin_in = 8'h0F;
            cyc(2);
            check("R8 restore releases int", {7'd0, int_n}, 8'h01);
            pin_in = 8'h0F ^ (8'h01 << i);
            cyc(2);
            rd(2'd0);
            check("R8 read clears int", {7'd0, int_n}, 8'h01);
            pin_in = 8'h0F;
            cyc(2);
            check("R7 return differs from new snapshot", {7'd0, int_n}, 8'h00);
            rd(2'd0);
            check("R8 read clears int again", {7'd0, int_n}, 8'h01);
            wr(2'd3, ~(8'h01 << i));
            pin_in = 8'h0F ^ (8'h01 << i);
            cyc(3);
            check("R7 output pin excluded", {7'd0, int_n}, 8'h01);
            pin_in = 8'h0F;
            cyc(2);
            wr(2'd3, 8'hFF);
            cyc(1);
            check("R7 int high after exclusion test", {7'd0, int_n}, 8'h01);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule